// File: doc/BRIEF.md
# Flash Completion Poller

This block runs on the host side of a parallel NOR-flash interface. After software or another controller has written a program or erase command sequence, it confirms that the device's internal operation has finished. A single start pulse latches the address to poll and the value bit 7 should show when the operation is complete. That value is the programmed datum's bit 7 for a program and 1 for any erase. The block then reads the device repeatedly through a simple request/acknowledge read port until it can decide the outcome.

Each status byte is judged on two bits. Bit 7 equal to the expected value means finished. Bit 5 set means the device reports that its internal time limit was exceeded. Bit 7 can change in the same read as bit 5, so a set bit 5 never fails the operation at once: the poller reads once more and decides on that second bit 7. The lower bits may still be stale on the read where bit 7 first matches, so a pass is always followed by one extra read, and that byte is handed back as the final data. A host-side poll limit can end a run on a stuck device with a distinct timeout flag.

Top module: `flpoll_ctrl`

## Requirements
- R1: Every read the block issues uses the address latched at the accepted start. `rd_req_o` stays high until a cycle with `rd_ack_i` high, and that cycle completes the read. The block compares bit 7 of the returned byte with the latched expected value.
- R2: A poll read whose bit 7 mismatches and whose bit 5 is 0 is followed by another poll read.
- R3: A poll read whose bit 7 mismatches and whose bit 5 is 1 is followed by exactly one confirming read. If bit 7 of that read matches, the run goes on to pass. If it mismatches, the run ends with fail and the timeout flag clear.
- R4: After any bit-7 match, one more read is made. The run ends with pass, and `final_data_o` holds the full byte from that extra read.
- R5: Erase polling uses an expected value of 1, and a busy device then shows 0 on bit 7. The same sequence applies with that value.
- R6: With `MAX_POLLS` nonzero, the run ends with fail and `timeout_o` set when `MAX_POLLS` poll reads have all shown a mismatching bit 7 with bit 5 clear. With `MAX_POLLS` = 0 there is no limit. `pass_o` and `timeout_o` are never both high.
- R7: If the last allowed poll read shows bit 5 set, the confirming read of R3 takes place and the timeout flag stays clear.
- R8: `start_i` is ignored while `busy_o` is high. Neither the address nor the expected value is relatched.
- R9: `done_o` is high for exactly one cycle, in the cycle after the acknowledge that ended the run. `pass_o` and `timeout_o` keep their values until the next accepted start, which clears them.
- R10: After reset the block is idle, with `rd_req_o`, `busy_o`, `done_o`, `pass_o` and `timeout_o` all low.
- R11: After a failed run, `final_data_o` holds the last byte that was read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| addr_i | input | AW | Valid address to poll |
| expect_i | input | 1 | Expected bit 7 on completion (1 for erase) |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_addr_o | output | AW | Read address |
| rd_ack_i | input | 1 | Read acknowledge; data valid in this cycle |
| rd_data_i | input | DW | Read data byte |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | Operation confirmed complete |
| timeout_o | output | 1 | Host poll limit reached |
| final_data_o | output | DW | Last byte read in the run |

## Verification
Two decisions can fall on the same acknowledge: the poll limit running out and bit 5 appearing. The bench sets up a status model whose bit 5 first rises on exactly the last allowed poll read. In one case bit 7 on the following read still mismatches, so the run must fail without the timeout flag. In the other case bit 7 flips on that read, so the run must pass after the extra read. The read counts are judged against the figures each path implies, and so is the flag pair.

// File: rtl/flpoll_pkg.sv
package flpoll_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_POLL    = 2'd1,
    ST_CONFIRM = 2'd2,
    ST_FINAL   = 2'd3
  } flpoll_st_e;

  // Completion test on the polled bit.
  function automatic logic status_hit(input logic seen, input logic want);
    return seen == want;
  endfunction

  // True when the poll now being acknowledged is the last one allowed.
  function automatic logic last_allowed(input int unsigned done_cnt,
                                        input int unsigned limit);
    return (limit != 0) && (done_cnt == limit - 1);
  endfunction

endpackage

// File: rtl/flpoll_status.sv
module flpoll_status
  import flpoll_pkg::*;
(
  input  logic poll_bit_i,
  input  logic tout_bit_i,
  input  logic expect_i,
  output logic hit_o,
  output logic tout_o
);
  assign hit_o  = status_hit(poll_bit_i, expect_i);
  assign tout_o = tout_bit_i;
endmodule

// File: rtl/flpoll_cnt.sv
module flpoll_cnt
  import flpoll_pkg::*;
#(
  parameter int MAX_POLLS = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int CW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) + 1 : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) cnt_q <= '0;
    else if (inc_i)      cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (MAX_POLLS == 0) begin : g_unlimited
      assign last_o = 1'b0 & (|cnt_q);
    end else begin : g_limited
      assign last_o = last_allowed(int'(cnt_q), MAX_POLLS);
    end
  endgenerate
endmodule

// File: rtl/flpoll_ctrl.sv
module flpoll_ctrl
  import flpoll_pkg::*;
#(
  parameter int AW        = 20,
  parameter int DW        = 8,
  parameter int POLL_BIT  = 7,
  parameter int TOUT_BIT  = 5,
  parameter int MAX_POLLS = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic          expect_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_ack_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          pass_o,
  output logic          timeout_o,
  output logic [DW-1:0] final_data_o
);

  flpoll_st_e    st_q, st_d;
  logic [AW-1:0] addr_q;
  logic          exp_q;
  logic          done_q, pass_q, tout_q;
  logic [DW-1:0] fdata_q;

  // named events, used by the checker
  logic ev_start_acc, ev_poll_ack, ev_b7_hit, ev_b5_seen;
  logic ev_b5_reread, ev_last_poll, ev_finish;
  logic fin_pass, fin_tout;

  assign ev_start_acc = start_i && (st_q == ST_IDLE);
  assign ev_poll_ack  = rd_ack_i && (st_q == ST_POLL);

  flpoll_status u_status (
    .poll_bit_i (rd_data_i[POLL_BIT]),
    .tout_bit_i (rd_data_i[TOUT_BIT]),
    .expect_i   (exp_q),
    .hit_o      (ev_b7_hit),
    .tout_o     (ev_b5_seen)
  );

  flpoll_cnt #(.MAX_POLLS(MAX_POLLS)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (ev_start_acc),
    .inc_i  (ev_poll_ack),
    .last_o (ev_last_poll)
  );

  assign ev_b5_reread = ev_poll_ack && !ev_b7_hit && ev_b5_seen;

  always_comb begin
    st_d     = st_q;
    ev_finish = 1'b0;
    fin_pass = 1'b0;
    fin_tout = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = ST_POLL;
      ST_POLL: if (rd_ack_i) begin
        if (ev_b7_hit)         st_d = ST_FINAL;
        else if (ev_b5_seen)   st_d = ST_CONFIRM;
        else if (ev_last_poll) begin
          st_d      = ST_IDLE;
          ev_finish = 1'b1;
          fin_tout  = 1'b1;
        end
      end
      ST_CONFIRM: if (rd_ack_i) begin
        if (ev_b7_hit) st_d = ST_FINAL;
        else begin
          st_d      = ST_IDLE;
          ev_finish = 1'b1;
        end
      end
      ST_FINAL: if (rd_ack_i) begin
        st_d      = ST_IDLE;
        ev_finish = 1'b1;
        fin_pass  = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      exp_q   <= 1'b0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
      tout_q  <= 1'b0;
      fdata_q <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= ev_finish;
      if (ev_start_acc) begin
        addr_q <= addr_i;
        exp_q  <= expect_i;
        pass_q <= 1'b0;
        tout_q <= 1'b0;
      end
      if (ev_finish) begin
        pass_q <= fin_pass;
        tout_q <= fin_tout;
      end
      if (rd_ack_i && (st_q != ST_IDLE)) fdata_q <= rd_data_i;
    end
  end

  assign busy_o       = (st_q != ST_IDLE);
  assign rd_req_o     = busy_o;
  assign rd_addr_o    = addr_q;
  assign done_o       = done_q;
  assign pass_o       = pass_q;
  assign timeout_o    = tout_q;
  assign final_data_o = fdata_q;

endmodule

// File: rtl/flpoll_chk.sv
module flpoll_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          pass_o,
  input logic          timeout_o,
  input logic          rd_req_o,
  input logic [AW-1:0] rd_addr_o,
  input logic          ev_b5_reread,
  input logic          ev_last_poll,
  input logic          ev_finish
);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !ev_finish) |=> (busy_o && $stable(rd_addr_o)));

  // R3
  b5_reread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_b5_reread |=> (busy_o && !done_o));

  // R7
  b5_over_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_b5_reread && ev_last_poll) |=> (busy_o && !timeout_o));

  // R6
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_o && timeout_o));

  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(pass_o) && $stable(timeout_o)));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !rd_req_o);
endmodule

bind flpoll_ctrl flpoll_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .pass_o       (pass_o),
  .timeout_o    (timeout_o),
  .rd_req_o     (rd_req_o),
  .rd_addr_o    (rd_addr_o),
  .ev_b5_reread (ev_b5_reread),
  .ev_last_poll (ev_last_poll),
  .ev_finish    (ev_finish)
);

// File: tb/tb_flpoll_ctrl.sv
module tb_flpoll_ctrl;
  localparam int CLK_NS = 10;
  localparam int AW = 20;
  localparam int LIM = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic expect_i = 1'b0;
  logic rd_req_o, rd_ack_i, busy_o, done_o, pass_o, timeout_o;
  logic [AW-1:0] rd_addr_o;
  logic [7:0] rd_data_i, final_data_o;

  int errors = 0;
  int checks = 0;

  always #(CLK_NS/2) clk = ~clk;

  flpoll_ctrl #(.AW(AW), .MAX_POLLS(LIM)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
    .expect_i(expect_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i), .busy_o(busy_o),
    .done_o(done_o), .pass_o(pass_o), .timeout_o(timeout_o),
    .final_data_o(final_data_o)
  );

  // behavioural device status model
  logic          cfg_exp = 1'b0;
  int            cfg_busy = 0;
  int            cfg_b5at = 255;
  logic [6:0]    cfg_lo = '0;
  logic [AW-1:0] cur_addr = '0;
  int            rd_k;
  int            addr_err;

  function automatic logic [7:0] dev_byte(input int k);
    if (k < cfg_busy)       return {~cfg_exp, 1'b0, (k >= cfg_b5at), 5'h0A};
    else if (k == cfg_busy) return {cfg_exp, 7'h2B};
    else                    return {cfg_exp, cfg_lo};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      rd_ack_i  <= 1'b0;
      rd_data_i <= '0;
      rd_k      <= 0;
      addr_err  <= 0;
    end else begin
      if (start_i && !busy_o) rd_k <= 0;
      if (rd_req_o && !rd_ack_i) begin
        rd_ack_i  <= 1'b1;
        rd_data_i <= dev_byte(rd_k);
        rd_k      <= rd_k + 1;
        if (rd_addr_o != cur_addr) addr_err <= addr_err + 1;
      end else begin
        rd_ack_i <= 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // exp, busy reads, bit5 index, low bits, pass, timeout, reads, final byte
  localparam logic [41:0] VEC [8] = '{
    {1'b0, 8'd0,   8'd255, 7'h11, 1'b1, 1'b0, 8'd2,  8'h11}, // R1 R4 immediate
    {1'b1, 8'd3,   8'd255, 7'h22, 1'b1, 1'b0, 8'd5,  8'hA2}, // R2 R5 erase
    {1'b0, 8'd5,   8'd255, 7'h33, 1'b1, 1'b0, 8'd7,  8'h33}, // R2 program
    {1'b1, 8'd2,   8'd1,   7'h44, 1'b1, 1'b0, 8'd4,  8'hC4}, // R3 flip with b5
    {1'b0, 8'd200, 8'd3,   7'h00, 1'b0, 1'b0, 8'd5,  8'hAA}, // R3 R11 real fail
    {1'b1, 8'd200, 8'd255, 7'h00, 1'b0, 1'b1, 8'd8,  8'h0A}, // R6 limit
    {1'b0, 8'd200, 8'd7,   7'h00, 1'b0, 1'b0, 8'd9,  8'hAA}, // R7 fail path
    {1'b1, 8'd8,   8'd7,   7'h55, 1'b1, 1'b0, 8'd10, 8'hD5}  // R7 pass path
  };

  task automatic run_vec(input logic [41:0] v, input logic [AW-1:0] a, input bit poke);
    int n;
    int e0;
    @(negedge clk);
    cfg_exp  = v[41];
    cfg_busy = int'(v[40:33]);
    cfg_b5at = int'(v[32:25]);
    cfg_lo   = v[24:18];
    cur_addr = a;
    addr_i   = a;
    expect_i = v[41];
    e0       = addr_err;
    start_i  = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(pass_o == 1'b0 && timeout_o == 1'b0, "R9 flags cleared on start", {pass_o, timeout_o}, 0);
    n = 0;
    while (!done_o && n < 3000) begin
      @(negedge clk);
      n++;
      if (poke && n == 2) begin
        start_i = 1'b1; addr_i = ~a; expect_i = ~v[41];
      end
      if (poke && n == 3) start_i = 1'b0;
    end
    chk(done_o == 1'b1, "R9 done seen", done_o, 1);
    chk(pass_o == v[17], "R3/R4/R6 pass flag", pass_o, v[17]);
    chk(timeout_o == v[16], "R6/R7 timeout flag", timeout_o, v[16]);
    chk(rd_k == int'(v[15:8]), "R2/R3/R4 read count", rd_k, v[15:8]);
    chk(final_data_o == v[7:0], "R4/R11 final data", final_data_o, v[7:0]);
    chk(addr_err == e0, "R1 R8 read address", addr_err - e0, 0);
    @(negedge clk);
    chk(done_o == 1'b0, "R9 done one cycle", done_o, 0);
  endtask

  initial begin
    #(CLK_NS * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!busy_o && !rd_req_o && !done_o && !pass_o && !timeout_o,
        "R10 reset state", {busy_o, rd_req_o, done_o, pass_o, timeout_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !rd_req_o, "R10 idle after reset", {busy_o, rd_req_o}, 0);

    for (int i = 0; i < 8; i++) run_vec(VEC[i], AW'(32'h1000 + i * 32'h111), 1'b0);

    // R8: start pulses while busy must not relatch address or expected value
    run_vec(VEC[2], AW'(32'h5A5A5), 1'b1);

    // R9: flags hold while idle, then clear on next start
    run_vec(VEC[5], AW'(32'h00777), 1'b0);
    repeat (5) @(negedge clk);
    chk(timeout_o == 1'b1 && pass_o == 1'b0, "R9 flags held while idle",
        {pass_o, timeout_o}, 1);
    run_vec(VEC[0], AW'(32'h00042), 1'b0);
    repeat (4) @(negedge clk);
    chk(pass_o == 1'b1 && final_data_o == 8'h11, "R9 pass held while idle",
        {pass_o, final_data_o}, 9'h111);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule